// File: doc/BRIEF.md
# CCD line timing pulse generator

This block produces the four per-line timing pulses that a CCD analog front end needs: an optical-black clamp, a dummy-black clamp, a pre-blanking pulse and a horizontal-clock blanking pulse. It keeps a 12-bit pixel counter and a 12-bit line counter. Both counters lock to externally supplied horizontal and vertical sync inputs. Each pulse is high over a programmed pixel window, which is given by a start and a stop position.

Window positions are written through a small parallel write port. A single mode input selects where the four pulses come from. In internal mode they are generated from the counters and the programmed windows. In external mode the pulses on four input pins are passed through instead. The output register is the same in both modes, so both have the same latency. A width-check output flags clamp windows whose programmed length lies outside the usable range.

Top module: `ccd_line_timer`

## Requirements
- R1: On a clock where `hsync_i` is high and was low on the previous clock, `pix_cnt_o` becomes 0 on the next clock. On any other clock it advances by one.
- R2: `line_cnt_o` advances by one on each rising edge of `hsync_i` and becomes 0 on a rising edge of `vsync_i`. When both edges arrive on the same clock, the vertical edge wins and the line count becomes 0.
- R3: Both counters stop at 4095 and do not wrap when no sync edge arrives.
- R4: In internal mode (`ext_mode_i` = 0), `pulse_o[k]` is the registered result of start[k] <= pixel count < stop[k], evaluated on the counter value of the previous clock. An empty window (start >= stop) never drives the pulse high.
- R5: In external mode (`ext_mode_i` = 1), `pulse_o` equals the value of `ext_pulse_i` on the previous clock, and the programmed windows have no effect.
- R6: The pulse index is encoded as 0 = optical-black clamp, 1 = dummy-black clamp, 2 = pre-blanking and 3 = horizontal blanking. A write with `wr_en_i` high stores `wr_data_i` into the register for that index. `wr_addr_i[2:1]` selects the index and `wr_addr_i[0]` selects start (0) or stop (1). The written value applies to the comparison from the next clock on.
- R7: `width_err_o[0]` is high whenever the optical-black window length lies outside 2..20 pixels. The length is stop - start when stop > start, and 0 otherwise.
- R8: `width_err_o[1]` is high whenever the dummy-black window length lies outside 4..10 pixels, with the length taken as in R7.
- R9: `rst_n` low clears the counters, the windows and `pulse_o` at once, so both width flags read 1. The block leaves reset on the second rising clock edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync; its rising edge restarts the line |
| vsync_i | input | 1 | Vertical sync; its rising edge restarts the field |
| ext_mode_i | input | 1 | 1 = pass external pulses through, 0 = generate them internally |
| ext_pulse_i | input | 4 | Externally supplied pulses, indexed as in R6 |
| wr_en_i | input | 1 | Window register write strobe |
| wr_addr_i | input | 3 | Pulse index in bits 2:1, start/stop select in bit 0 |
| wr_data_i | input | 12 | Pixel position to store |
| pulse_o | output | 4 | Registered timing pulses, indexed as in R6 |
| pix_cnt_o | output | 12 | Current pixel count |
| line_cnt_o | output | 12 | Current line count |
| width_err_o | output | 2 | Bit 0: optical-black length out of range; bit 1: dummy-black length out of range |

## Verification
The hardest state to reach from the ports is line-counter saturation. It needs more than four thousand horizontal edges with no vertical edge in between. The stimulus reaches it by running very short lines, one sync cycle plus three idle cycles, for about 16,000 clocks. Pixel saturation is reached by holding horizontal sync low for more than 4096 clocks, with one window ending exactly at 4095. This shows that the last pixel lies outside the half-open window. A line where both syncs rise on the same clock, and mode switches in the middle of a line, cover the tie rule and the identical latency of the two paths.

// File: rtl/ccd_lt_pkg.sv
package ccd_lt_pkg;
  localparam int CNT_W  = 12;
  localparam int NPULSE = 4;

  typedef enum logic [1:0] {
    PI_OBCLAMP = 2'd0,
    PI_DMCLAMP = 2'd1,
    PI_PREBLK  = 2'd2,
    PI_HBLANK  = 2'd3
  } pulse_idx_e;
endpackage

// File: rtl/lt_counters.sv
module lt_counters #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hsync_i,
  input  logic         vsync_i,
  output logic [W-1:0] pix_o,
  output logic [W-1:0] line_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic         hs_q, vs_q;
  logic         hs_rise, vs_rise;
  logic [W-1:0] pix_q, pix_d, line_q, line_d;

  always_comb begin
    hs_rise = hsync_i & ~hs_q;
    vs_rise = vsync_i & ~vs_q;
    if (hs_rise)            pix_d = '0;
    else if (pix_q == CMAX) pix_d = pix_q;
    else                    pix_d = pix_q + 1'b1;
    if (vs_rise)             line_d = '0;
    else if (!hs_rise)       line_d = line_q;
    else if (line_q == CMAX) line_d = line_q;
    else                     line_d = line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      hs_q   <= hsync_i;
      vs_q   <= vsync_i;
      pix_q  <= pix_d;
      line_q <= line_d;
    end
  end

  assign pix_o  = pix_q;
  assign line_o = line_q;

  assert_pix_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_i && !hs_q) |=> (pix_o == '0));
  assert_pix_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hsync_i && !hs_q) && pix_o != CMAX) |=> (pix_o == $past(pix_o) + 1'b1));
  assert_line_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_i && !vs_q) |=> (line_o == '0));
  assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_i && !hsync_i) |=> $stable(line_o));
  assert_pix_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_o == CMAX && !hsync_i) |=> (pix_o == CMAX));
endmodule

// File: rtl/lt_window_bank.sv
module lt_window_bank #(
  parameter int W = 12,
  parameter int N = 4,
  parameter int AW = $clog2(N) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [W-1:0]        wr_data_i,
  input  logic [W-1:0]        pix_i,
  output logic [N-1:0][W-1:0] start_o,
  output logic [N-1:0][W-1:0] stop_o,
  output logic [N-1:0]        hit_o
);
  logic [N-1:0][W-1:0] start_q, stop_q;

  for (genvar k = 0; k < N; k++) begin : g_win
    logic sel;
    logic wr_start, wr_stop;
    assign sel      = wr_en_i && (wr_addr_i[AW-1:1] == k[AW-2:0]);
    assign wr_start = sel && !wr_addr_i[0];
    assign wr_stop  = sel &&  wr_addr_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[k] <= '0;
        stop_q[k]  <= '0;
      end else begin
        if (wr_start) start_q[k] <= wr_data_i;
        if (wr_stop)  stop_q[k]  <= wr_data_i;
      end
    end

    assign hit_o[k] = (start_q[k] <= pix_i) && (pix_i < stop_q[k]);
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
endmodule

// File: rtl/lt_width_chk.sv
module lt_width_chk #(
  parameter int W = 12,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 20
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] stop_i,
  output logic         err_o
);
  logic [W-1:0] len;

  always_comb begin
    len   = (stop_i > start_i) ? (stop_i - start_i) : '0;
    err_o = (len < W'(MIN_LEN)) || (len > W'(MAX_LEN));
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_lt_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int N      = NPULSE,
  parameter int OB_MIN = 2,
  parameter int OB_MAX = 20,
  parameter int DM_MIN = 4,
  parameter int DM_MAX = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hsync_i,
  input  logic                   vsync_i,
  input  logic                   ext_mode_i,
  input  logic [N-1:0]           ext_pulse_i,
  input  logic                   wr_en_i,
  input  logic [$clog2(N):0]     wr_addr_i,
  input  logic [W-1:0]           wr_data_i,
  output logic [N-1:0]           pulse_o,
  output logic [W-1:0]           pix_cnt_o,
  output logic [W-1:0]           line_cnt_o,
  output logic [1:0]             width_err_o
);
  localparam int AW = $clog2(N) + 1;

  logic [1:0]          rst_sync;
  logic                rst_int;
  logic [W-1:0]        pix, line;
  logic [N-1:0][W-1:0] win_start, win_stop;
  logic [N-1:0]        hit;
  logic [N-1:0]        pulse_d, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  lt_counters #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_int), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .pix_o(pix), .line_o(line)
  );

  lt_window_bank #(.W(W), .N(N), .AW(AW)) u_win (
    .clk(clk), .rst_n(rst_int), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pix_i(pix),
    .start_o(win_start), .stop_o(win_stop), .hit_o(hit)
  );

  lt_width_chk #(.W(W), .MIN_LEN(OB_MIN), .MAX_LEN(OB_MAX)) u_ob_chk (
    .start_i(win_start[PI_OBCLAMP]), .stop_i(win_stop[PI_OBCLAMP]),
    .err_o(width_err_o[0])
  );

  lt_width_chk #(.W(W), .MIN_LEN(DM_MIN), .MAX_LEN(DM_MAX)) u_dm_chk (
    .start_i(win_start[PI_DMCLAMP]), .stop_i(win_stop[PI_DMCLAMP]),
    .err_o(width_err_o[1])
  );

  always_comb begin
    pulse_d = ext_mode_i ? ext_pulse_i : hit;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) pulse_q <= '0;
    else          pulse_q <= pulse_d;
  end

  assign pulse_o    = pulse_q;
  assign pix_cnt_o  = pix;
  assign line_cnt_o = line;

  assert_ext_pass_R5: assert property (@(posedge clk) disable iff (!rst_int)
    ext_mode_i |=> (pulse_o == $past(ext_pulse_i)));

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_empty_win_R4: assert property (@(posedge clk) disable iff (!rst_int)
      (!ext_mode_i && win_start[k] >= win_stop[k]) |=> !pulse_o[k]);
  end
endmodule

// File: tb/sim_ccd_line_timer.sv
module sim_ccd_line_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hs, vs, ext_mode, wr_en;
  logic [3:0]  ext_p;
  logic [2:0]  wr_addr;
  logic [11:0] wr_data;
  logic [3:0]  pulse_o;
  logic [11:0] pix_o, line_o;
  logic [1:0]  werr_o;

  always #5 clk = ~clk;

  ccd_line_timer u0 (
    .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs),
    .ext_mode_i(ext_mode), .ext_pulse_i(ext_p), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pulse_o(pulse_o),
    .pix_cnt_o(pix_o), .line_cnt_o(line_o), .width_err_o(werr_o)
  );

  int tests = 0, fails = 0;
  bit started = 0, done = 0, in_rst = 1;
  int m_r1 = 0, m_r2 = 0;
  int m_pix, m_line, m_hsq, m_vsq, m_pulse;
  int m_st[4], m_sp[4];
  int cyc = 0;

  function automatic int wlen(int s, int e);
    return (e > s) ? e - s : 0;
  endfunction

  task automatic m_clear();
    m_pix = 0; m_line = 0; m_hsq = 0; m_vsq = 0; m_pulse = 0;
    for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_sp[k] = 0; end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int act, np, hr, vr;
    started = 1;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; in_rst = 1; m_clear();
    end else begin
      act = m_r2; m_r2 = m_r1; m_r1 = 1;
      if (!act) begin in_rst = 1; m_clear(); end
      else begin
        in_rst = 0;
        np = 0;
        for (int k = 0; k < 4; k++) begin
          if (ext_mode) np |= (ext_p[k] ? 1 : 0) << k;
          else if (m_st[k] <= m_pix && m_pix < m_sp[k]) np |= 1 << k;
        end
        hr = hs && !m_hsq;
        vr = vs && !m_vsq;
        if (hr) m_pix = 0;
        else if (m_pix < 4095) m_pix = m_pix + 1;
        if (vr) m_line = 0;
        else if (hr && m_line < 4095) m_line = m_line + 1;
        m_hsq = hs; m_vsq = vs;
        if (wr_en) begin
          if (wr_addr[0]) m_sp[wr_addr[2:1]] = wr_data;
          else            m_st[wr_addr[2:1]] = wr_data;
        end
        m_pulse = np;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int ew;
    if (started && !done) begin
      ew = 0;
      if (wlen(m_st[0], m_sp[0]) < 2 || wlen(m_st[0], m_sp[0]) > 20) ew |= 1;
      if (wlen(m_st[1], m_sp[1]) < 4 || wlen(m_st[1], m_sp[1]) > 10) ew |= 2;
      if (in_rst) begin
        chk("R9 reset pulse", pulse_o, 0);
        chk("R9 reset pixel", pix_o, 0);
        chk("R9 reset line", line_o, 0);
        chk("R9 reset width flags", werr_o, 3);
      end else begin
        chk(ext_mode ? "R5 pulse" : "R4/R6 pulse", pulse_o, m_pulse);
        chk(m_pix == 4095 ? "R3 pixel" : "R1 pixel", pix_o, m_pix);
        chk(m_line == 4095 ? "R3 line" : "R2 line", line_o, m_line);
        chk("R7 ob width", werr_o[0], ew & 1);
        chk("R8 dm width", werr_o[1], (ew >> 1) & 1);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int idx, int stp, int val);
    wr_en = 1; wr_addr = {idx[1:0], stp[0]}; wr_data = val[11:0];
    step(1);
    wr_en = 0;
  endtask

  task automatic line(int len, int hsw, bit vs_on);
    for (int c = 0; c < len; c++) begin
      hs = (c < hsw);
      vs = vs_on && (c < hsw + 2);
      ext_p = $urandom;
      step(1);
    end
  endtask

  initial begin
    rst_n = 0; hs = 0; vs = 0; ext_mode = 0; ext_p = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    step(3);
    rst_n = 1;
    step(4);
    // R6: program the four windows through the write port
    wr(0, 0, 10); wr(0, 1, 14);
    wr(1, 0, 20); wr(1, 1, 26);
    wr(2, 0, 0);  wr(2, 1, 5);
    wr(3, 0, 30); wr(3, 1, 100);
    // R1 R2 R4: frames, first line has both syncs rising together
    for (int f = 0; f < 3; f++) begin
      line(120, 3, 1);
      for (int l = 0; l < 6; l++) line(120, 3, 0);
    end
    // R7 R8: boundary and illegal clamp lengths
    wr(0, 1, 40); line(60, 2, 0);
    wr(0, 1, 11); line(60, 2, 0);
    wr(0, 1, 12); line(60, 2, 0);
    wr(0, 1, 30); line(60, 2, 0);
    wr(0, 1, 31); line(60, 2, 0);
    wr(0, 0, 50); line(60, 2, 0);
    wr(1, 1, 22); line(60, 2, 0);
    wr(1, 1, 24); line(60, 2, 0);
    wr(1, 1, 30); line(60, 2, 0);
    wr(1, 1, 31); line(60, 2, 0);
    wr(0, 0, 10); wr(0, 1, 14); wr(1, 1, 26);
    // R5: external pass-through, then switch modes mid-line
    ext_mode = 1;
    for (int l = 0; l < 5; l++) line(80, 2, 0);
    for (int l = 0; l < 4; l++) begin
      hs = 1; step(2); hs = 0;
      for (int c = 0; c < 70; c++) begin
        ext_p = $urandom;
        if (c == 25) ext_mode = ~ext_mode;
        step(1);
      end
    end
    ext_mode = 0;
    // R3: pixel saturation, window ending exactly at the last pixel
    wr(3, 0, 4000); wr(3, 1, 4095);
    wr(2, 0, 0);    wr(2, 1, 4095);
    hs = 1; step(1); hs = 0;
    step(4300);
    // R3: line saturation with very short lines and no vertical sync
    for (int l = 0; l < 4110; l++) line(4, 1, 0);
    line(20, 2, 1);
    line(20, 2, 0);
    // R9: reset again in mid-operation
    rst_n = 0; step(3);
    rst_n = 1; step(5);
    finish_run();
  end
endmodule